// File: doc/BRIEF.md
# Dual-Channel DMA Stall Monitor

This block watches two DMA engine state machines and flags a channel that has stopped making forward progress. Each channel's 6-bit state and 16-bit queue number are taken from two shared status words. A fast layer counts, in core clocks, how long each channel's state has stayed unchanged. A slow layer runs on an evaluation strobe and turns that count into a stall duration measured in slow ticks.

A channel is stuck once its unchanged-state count reaches a programmable clocks-per-second threshold. While it stays stuck, the block emits a warning pulse on the first evaluation and again every 300 seconds of slow ticks. Each warning carries the captured state, the queue number and the stall length in whole seconds. When the channel moves again, a resume pulse reports how long the stall lasted.

Each channel runs a two-state machine. In `MON_IDLE` the stall timer is zero. The transition *enter* (strobe while count >= threshold) moves to `MON_STALLED`, loading the timer with one second of ticks and clearing the countdown. The transition *accumulate* (strobe while still stuck) stays in `MON_STALLED` and advances the timer and countdown. The transition *recover* (strobe while count < threshold) returns to `MON_IDLE` and clears the timer.

Top module: `dma_stall_monitor`

## Requirements
- R1: Both channels (0 and 1) are monitored independently; a stall on one produces no pulse on the other.
- R2: A channel's same-state counter rises by one on each clock whose state equals the state of the clock before and returns to zero on a change. It stops at all ones and does not wrap.
- R3: On a strobe, a channel counts as stuck exactly when its same-state counter is greater than or equal to `one_sec_clocks`.
- R4: On the strobe that enters `MON_STALLED`, the stall timer becomes `TICKS_PER_SEC` and the countdown becomes zero. A warning therefore fires on that strobe, reporting 1 second.
- R5: Each later strobe in `MON_STALLED` adds `ticks_elapsed` to the stall timer and subtracts it from a signed countdown. A warning fires when the countdown is zero or below, and the countdown is then reloaded with `WARN_REPEAT_SEC * TICKS_PER_SEC`. The reported seconds are the stall timer divided by `TICKS_PER_SEC`, rounded down.
- R6: A strobe that finds a `MON_STALLED` channel no longer stuck emits a resume pulse with the stall seconds (timer / `TICKS_PER_SEC`, without adding the current ticks). It clears the timer, so the next strobe gives no further resume.
- R7: Channel c's state is bits [9c+5 : 9c] of `state_word`. Bits outside the two fields (for example bit 7) have no effect.
- R8: Channel c's queue number is bits [16c+15 : 16c] of `qid_word`. State and queue number are recaptured on every warning.
- R9: Warning and resume outputs are one-cycle pulses, registered one cycle after the strobe. A synchronous active-high reset clears all counters, timers and countdowns, and no pulse appears while reset is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| state_word | input | 32 | Packed channel states, channel c at bit 9c |
| qid_word | input | 32 | Packed queue numbers, channel c at bit 16c |
| one_sec_clocks | input | CNT_W | Core clocks per second; stuck threshold |
| eval_strobe | input | 1 | One-cycle evaluation request |
| ticks_elapsed | input | ELAPSED_W | Slow ticks since the previous strobe |
| warn_pulse | output | 2 | Per-channel warning pulse |
| resume_pulse | output | 2 | Per-channel resume pulse |
| evt_state | output | 12 | Captured state, channel c at bits [6c+5:6c] |
| evt_qid | output | 32 | Captured queue number, channel c at bits [16c+15:16c] |
| evt_seconds | output | 2*TIMER_W | Stall seconds, channel c at bits [TIMER_W*c +: TIMER_W] |

## Verification
The bench builds the block with an 8-bit same-state counter, four slow ticks per second, a 16-bit stall timer and an 8-bit elapsed count, and keeps the 300-second repeat. The narrow counter lets a few hundred cycles of a held state reach saturation against a threshold of 255. With four ticks per second the 1200-tick repeat interval is reached in a handful of strobes, both by landing exactly on zero and by overshooting below zero. A threshold of 20 or 10 places the stuck boundary at a cycle the bench can count exactly.

// File: rtl/dma_stall_pkg.sv
package dma_stall_pkg;
    localparam int NUM_CH       = 2;
    localparam int STATE_W      = 6;
    localparam int QID_W        = 16;
    localparam int STATE_STRIDE = 9;
    localparam int QID_STRIDE   = 16;
    localparam int STATE_WORD_W = 32;
    localparam int QID_WORD_W   = 32;

    typedef enum logic {
        MON_IDLE    = 1'b0,
        MON_STALLED = 1'b1
    } mon_mode_e;
endpackage

// File: rtl/same_state_counter.sv
module same_state_counter #(
    parameter int CNT_W   = 32,
    parameter int STATE_W = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [STATE_W-1:0] state_i,
    output logic [CNT_W-1:0]   count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [STATE_W-1:0] prev_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               same;

    assign same    = (state_i == prev_q);
    assign count_o = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            cnt_q  <= '0;
        end else begin
            prev_q <= state_i;
            if (!same)
                cnt_q <= '0;
            else if (cnt_q != CNT_MAX)
                cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assert_sat_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (same && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        (same && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
    assert_restart_R2: assert property (@(posedge clk) disable iff (rst)
        (!same) |=> (cnt_q == '0));
endmodule

// File: rtl/stall_tracker.sv
module stall_tracker
    import dma_stall_pkg::*;
#(
    parameter int TIMER_W         = 32,
    parameter int ELAPSED_W       = 16,
    parameter int TICKS_PER_SEC   = 100,
    parameter int WARN_REPEAT_SEC = 300
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 eval_i,
    input  logic [ELAPSED_W-1:0] elapsed_i,
    input  logic                 stuck_i,
    input  logic [STATE_W-1:0]   cur_state_i,
    input  logic [QID_W-1:0]     cur_qid_i,
    output logic                 warn_o,
    output logic                 resume_o,
    output logic [STATE_W-1:0]   evt_state_o,
    output logic [QID_W-1:0]     evt_qid_o,
    output logic [TIMER_W-1:0]   evt_secs_o
);
    localparam int RELOAD_TICKS = WARN_REPEAT_SEC * TICKS_PER_SEC;
    localparam int WARN_W = $clog2(RELOAD_TICKS + (2 ** ELAPSED_W)) + 1;
    localparam logic [TIMER_W-1:0] ONE_SEC = TIMER_W'(TICKS_PER_SEC);
    localparam logic signed [WARN_W-1:0] RELOAD = WARN_W'(RELOAD_TICKS);

    mon_mode_e                mode_q, mode_d;
    logic [TIMER_W-1:0]       timer_q, timer_d;
    logic signed [WARN_W-1:0] cd_q, cd_d, elapsed_s;
    logic [TIMER_W:0]         timer_sum;
    logic                     fire, recover;

    assign elapsed_s = WARN_W'(elapsed_i);
    assign timer_sum = {1'b0, timer_q} + (TIMER_W + 1)'(elapsed_i);

    // Next-state and datapath decision
    always_comb begin
        mode_d  = mode_q;
        timer_d = timer_q;
        cd_d    = cd_q;
        fire    = 1'b0;
        recover = 1'b0;
        if (eval_i) begin
            unique case (mode_q)
                MON_IDLE: begin
                    if (stuck_i) begin           // enter
                        mode_d  = MON_STALLED;
                        timer_d = ONE_SEC;
                        cd_d    = '0;
                    end
                end
                MON_STALLED: begin
                    if (!stuck_i) begin          // recover
                        mode_d  = MON_IDLE;
                        recover = (timer_q >= ONE_SEC);
                        timer_d = '0;
                    end else begin               // accumulate
                        timer_d = timer_sum[TIMER_W] ? {TIMER_W{1'b1}}
                                                     : timer_sum[TIMER_W-1:0];
                        cd_d    = cd_q - elapsed_s;
                    end
                end
            endcase
            if (mode_d == MON_STALLED && timer_d >= ONE_SEC && cd_d <= 0) begin
                fire = 1'b1;
                cd_d = RELOAD;
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) mode_q <= MON_IDLE;
        else     mode_q <= mode_d;
    end

    // Outputs and per-channel datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            timer_q     <= '0;
            cd_q        <= '0;
            warn_o      <= 1'b0;
            resume_o    <= 1'b0;
            evt_state_o <= '0;
            evt_qid_o   <= '0;
            evt_secs_o  <= '0;
        end else begin
            timer_q  <= timer_d;
            cd_q     <= cd_d;
            warn_o   <= fire;
            resume_o <= recover;
            if (fire) begin
                evt_state_o <= cur_state_i;
                evt_qid_o   <= cur_qid_i;
                evt_secs_o  <= timer_d / ONE_SEC;
            end else if (recover) begin
                evt_secs_o  <= timer_q / ONE_SEC;
            end
        end
    end

    assert_warn_reload_R5: assert property (@(posedge clk) disable iff (rst)
        warn_o |-> (cd_q == RELOAD));
    assert_first_warn_one_sec_R4: assert property (@(posedge clk) disable iff (rst)
        (warn_o && $past(mode_q) == MON_IDLE) |-> (evt_secs_o == TIMER_W'(1)));
    assert_idle_timer_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MON_IDLE) |-> (timer_q == '0));
    assert_resume_leaves_stall_R6: assert property (@(posedge clk) disable iff (rst)
        resume_o |-> (mode_q == MON_IDLE && $past(mode_q) == MON_STALLED));
    assert_pulse_needs_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        (warn_o || resume_o) |-> $past(eval_i));
    assert_pulse_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(warn_o && resume_o));
endmodule

// File: rtl/dma_stall_monitor.sv
module dma_stall_monitor
    import dma_stall_pkg::*;
#(
    parameter int CNT_W           = 32,
    parameter int TIMER_W         = 32,
    parameter int ELAPSED_W       = 16,
    parameter int TICKS_PER_SEC   = 100,
    parameter int WARN_REPEAT_SEC = 300
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [STATE_WORD_W-1:0]    state_word,
    input  logic [QID_WORD_W-1:0]      qid_word,
    input  logic [CNT_W-1:0]           one_sec_clocks,
    input  logic                       eval_strobe,
    input  logic [ELAPSED_W-1:0]       ticks_elapsed,
    output logic [NUM_CH-1:0]          warn_pulse,
    output logic [NUM_CH-1:0]          resume_pulse,
    output logic [NUM_CH*STATE_W-1:0]  evt_state,
    output logic [NUM_CH*QID_W-1:0]    evt_qid,
    output logic [NUM_CH*TIMER_W-1:0]  evt_seconds
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [STATE_W-1:0] ch_state;
        logic [QID_W-1:0]   ch_qid;
        logic [CNT_W-1:0]   same_cnt;
        logic               stuck;

        assign ch_state = state_word[c*STATE_STRIDE +: STATE_W];
        assign ch_qid   = qid_word[c*QID_STRIDE +: QID_W];
        assign stuck    = (same_cnt >= one_sec_clocks);

        same_state_counter #(
            .CNT_W   (CNT_W),
            .STATE_W (STATE_W)
        ) u_cnt (
            .clk     (clk),
            .rst     (rst),
            .state_i (ch_state),
            .count_o (same_cnt)
        );

        stall_tracker #(
            .TIMER_W         (TIMER_W),
            .ELAPSED_W       (ELAPSED_W),
            .TICKS_PER_SEC   (TICKS_PER_SEC),
            .WARN_REPEAT_SEC (WARN_REPEAT_SEC)
        ) u_trk (
            .clk         (clk),
            .rst         (rst),
            .eval_i      (eval_strobe),
            .elapsed_i   (ticks_elapsed),
            .stuck_i     (stuck),
            .cur_state_i (ch_state),
            .cur_qid_i   (ch_qid),
            .warn_o      (warn_pulse[c]),
            .resume_o    (resume_pulse[c]),
            .evt_state_o (evt_state[c*STATE_W +: STATE_W]),
            .evt_qid_o   (evt_qid[c*QID_W +: QID_W]),
            .evt_secs_o  (evt_seconds[c*TIMER_W +: TIMER_W])
        );
    end

    assert_no_pulse_without_strobe_R1: assert property (@(posedge clk) disable iff (rst)
        (warn_pulse != '0 || resume_pulse != '0) |-> $past(eval_strobe));
endmodule

// File: tb/test_dma_stall_monitor.sv
`timescale 1ns/1ps
module test_dma_stall_monitor;
    localparam int CNT_W = 8, TIMER_W = 16, ELAPSED_W = 8, HZ = 4, REP = 300;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                   rst;
    logic [31:0]            state_word, qid_word;
    logic [CNT_W-1:0]       thr;
    logic                   eval;
    logic [ELAPSED_W-1:0]   elapsed;
    logic [1:0]             warn, resume;
    logic [11:0]            evt_state;
    logic [31:0]            evt_qid;
    logic [2*TIMER_W-1:0]   evt_secs;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    dma_stall_monitor #(
        .CNT_W(CNT_W), .TIMER_W(TIMER_W), .ELAPSED_W(ELAPSED_W),
        .TICKS_PER_SEC(HZ), .WARN_REPEAT_SEC(REP)
    ) i_dma_stall_monitor (
        .clk(clk), .rst(rst), .state_word(state_word), .qid_word(qid_word),
        .one_sec_clocks(thr), .eval_strobe(eval), .ticks_elapsed(elapsed),
        .warn_pulse(warn), .resume_pulse(resume), .evt_state(evt_state),
        .evt_qid(evt_qid), .evt_seconds(evt_secs)
    );

    task automatic check(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Wait n cycles from a negedge; mask bit0 toggles ch0, bit1 ch1, bit2 spare bit 7
    task automatic hold(int n, logic [2:0] mask);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (mask[0]) state_word[0] = ~state_word[0];
            if (mask[1]) state_word[9] = ~state_word[9];
            if (mask[2]) state_word[7] = ~state_word[7];
        end
    endtask

    // One-cycle strobe from a negedge; outputs are valid at the following negedge
    task automatic strobe(int e);
        eval = 1'b1;
        elapsed = ELAPSED_W'(e);
        @(negedge clk);
        eval = 1'b0;
        elapsed = '0;
    endtask

    task automatic t_reset_state();
        check("R9", "warn after reset", warn, 0);
        check("R9", "resume after reset", resume, 0);
        check("R9", "seconds after reset", evt_secs, 0);
        check("R9", "state after reset", evt_state, 0);
    endtask

    task automatic t_threshold_first_warn();
        thr = 8'd20;
        state_word[5:0] = 6'h2A;
        qid_word[15:0] = 16'h1234;
        hold(20, 3'b010);
        strobe(1);                               // count 19 < 20
        check("R3", "no warn below threshold", warn[0], 0);
        strobe(1);                               // count 20 >= 20
        check("R3", "warn at threshold", warn[0], 1);
        check("R4", "first warn seconds", evt_secs[15:0], 1);
        check("R7", "captured state ch0", evt_state[5:0], 6'h2A);
        check("R8", "captured qid ch0", evt_qid[15:0], 16'h1234);
        hold(1, 3'b010);
        check("R9", "warn is single cycle", warn[0], 0);
    endtask

    task automatic t_repeat_warn();
        for (int i = 0; i < 5; i++) begin
            hold(1, 3'b010);
            strobe(200);
            check("R5", "no warn while countdown positive", warn[0], 0);
        end
        qid_word[15:0] = 16'hBEEF;
        hold(1, 3'b010);
        strobe(200);                             // countdown reaches 0
        check("R5", "warn at countdown zero", warn[0], 1);
        check("R5", "seconds at second warn", evt_secs[15:0], 301);
        check("R8", "qid recaptured", evt_qid[15:0], 16'hBEEF);
        for (int i = 0; i < 4; i++) begin
            hold(1, 3'b010);
            strobe(255);
            check("R5", "no warn before overshoot", warn[0], 0);
        end
        hold(1, 3'b010);
        strobe(255);                             // countdown -75
        check("R5", "warn at negative countdown", warn[0], 1);
        check("R5", "seconds at third warn", evt_secs[15:0], 619);
    endtask

    task automatic t_resume();
        state_word[5:0] = 6'h11;
        hold(1, 3'b010);
        strobe(1);
        check("R6", "resume pulse", resume[0], 1);
        check("R6", "resume seconds", evt_secs[15:0], 619);
        check("R6", "no warn on resume", warn[0], 0);
        hold(3, 3'b011);
        strobe(1);
        check("R6", "no second resume", resume[0], 0);
    endtask

    task automatic t_independent_channels();
        thr = 8'd10;
        state_word[14:9] = 6'h15;
        qid_word[31:16] = 16'hCAFE;
        hold(15, 3'b101);
        strobe(1);
        check("R1", "ch1 warns", warn[1], 1);
        check("R1", "ch0 quiet", warn[0], 0);
        check("R7", "captured state ch1 with bit 7 toggling", evt_state[11:6], 6'h15);
        check("R8", "captured qid ch1", evt_qid[31:16], 16'hCAFE);
        check("R4", "ch1 first warn seconds", evt_secs[31:16], 1);
    endtask

    task automatic t_saturation();
        thr = 8'hFF;
        state_word[5:0] = 6'h3C;
        hold(300, 3'b010);
        strobe(1);
        check("R2", "saturated count reaches max threshold", warn[0], 1);
        hold(300, 3'b010);
        strobe(1);
        check("R2", "no resume while saturated", resume[0], 0);
        check("R2", "no warn inside repeat interval", warn[0], 0);
    endtask

    task automatic t_reset_mid_stall();
        rst = 1'b1;
        eval = 1'b1;
        elapsed = 8'd5;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R9", "no warn in reset", warn, 0);
            check("R9", "no resume in reset", resume, 0);
        end
        rst = 1'b0;
        eval = 1'b0;
        elapsed = '0;
        hold(3, 3'b010);
        strobe(1);
        check("R9", "reset cleared stall timer", resume[0], 0);
    endtask

    initial begin
        rst = 1'b1;
        state_word = '0;
        qid_word = '0;
        thr = 8'd20;
        eval = 1'b0;
        elapsed = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_threshold_first_warn();
        t_repeat_warn();
        t_resume();
        t_independent_channels();
        t_saturation();
        t_reset_mid_stall();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule